// File: doc/BRIEF.md
# Interleaved Block Transfer Sequencer

This block drives long block moves between a local memory port and a backplane bus whose bursts are limited in length. Software programs a backplane start address, a local start address, a total byte count and a control word, then pulses `start`. The sequencer requests the backplane, and once it holds the bus it issues beats. Each beat needs an acknowledge from both the backplane side and the local side. After each beat both address counters advance by the beat size.

A burst ends for one of three reasons. The backplane address can reach an alignment boundary: 256 bytes in 32-bit mode, 2048 bytes in 64-bit mode. The programmed beats-per-burst cap can be reached. The transfer can be complete. When a burst ends and bytes remain, the sequencer releases the bus and holds both addresses. It then waits a programmable interleave period, with a flag telling the surrounding logic that slave accesses may be served, and requests the bus again. A one-cycle done pulse and a sticky interrupt mark completion.

A separate address counter serves incoming slave block transfers: it is loaded with a captured base address and stepped once per slave beat.

Top module: `ilv_burst_seq`

## Requirements
- R1: After reset, `busy`, `bus_req`, `bp_beat_req`, `loc_beat_req`, `gap_open`, `done` and `irq` are all 0.
- R2: Configuration writes address four registers: 0 is the backplane start address, 1 is the local start address, 2 is the byte length, and 3 is the control word. The control word fields are: bits [1:0] beat size code, bit 2 selects 64-bit mode, bits [15:8] are the beats-per-burst cap (0 means no cap), and bits [23:16] are the interleave period P. Writes made while `busy` is high are ignored.
- R3: A `start` pulse in idle loads both address counters from the registers. On the next cycle `busy` and `bus_req` go high, and beats are issued only after `bus_grant`.
- R4: The beat size is 1, 2, 4 or 8 bytes for codes 0, 1, 2, 3. During a beat, each side's request stays high until that side acknowledges, then drops while the other side is still pending. The beat completes when both sides have acknowledged. Both counters then advance by the beat size.
- R5: A burst ends after a beat that leaves the backplane address on a multiple of 256 bytes (32-bit mode) or of 2048 bytes (64-bit mode).
- R6: With a nonzero cap N, a burst ends after N beats.
- R7: When a burst ends with bytes remaining, `bus_req` drops for exactly P+1 cycles with `gap_open` high, then rises again. Both addresses are held throughout. A period of 0 re-requests on the next clock.
- R8: After the last beat, `busy` and `bus_req` fall and `done` is high for exactly one cycle. Both counters then point one byte past the end of their ranges.
- R9: `irq` rises on the cycle after `done` and stays high until `irq_ack` is pulsed.
- R10: A `start` with length 0 gives a `done` pulse on the next cycle without requesting the bus.
- R11: The slave counter loads `slv_base` on `slv_load`, and advances by the size coded in `slv_size` (same codes as R4) on each `slv_inc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | CFG_DW | Configuration write data |
| start | input | 1 | Launch a transfer |
| bus_req | output | 1 | Backplane bus request |
| bus_grant | input | 1 | Backplane bus grant |
| bp_beat_req | output | 1 | Beat request toward backplane side |
| bp_beat_ack | input | 1 | Backplane beat acknowledge |
| bp_addr | output | BP_AW | Backplane address counter |
| loc_beat_req | output | 1 | Beat request toward local side |
| loc_beat_ack | input | 1 | Local beat acknowledge |
| loc_addr | output | LC_AW | Local address counter |
| gap_open | output | 1 | Interleave wait in progress; slave access window |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Sticky completion interrupt |
| irq_ack | input | 1 | Clears the interrupt |
| slv_load | input | 1 | Load slave block counter |
| slv_base | input | BP_AW | Slave block start address |
| slv_inc | input | 1 | Advance slave block counter |
| slv_size | input | 2 | Slave beat size code |
| slv_addr | output | BP_AW | Slave block address counter |

## Verification
The bench uses the default parameters: 32-bit addresses, a 16-bit length and 8-bit cap and period fields. It sweeps every beat size, both bus modes, caps of 0 and 5, and interleave periods of 0 and 3 over a 48-byte transfer placed 24 bytes below a boundary. This exercises boundary splits, cap splits, their coincidence and cap-then-remainder bursts. Extra runs cross a 256-byte line in 64-bit mode without splitting, check that writes during a busy transfer are ignored, launch a zero-length transfer, and step the slave counter at all four sizes. Local acknowledges arrive with a varying lag, which exercises the two-sided beat handshake.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    localparam int CAP_W   = 8;
    localparam int PER_W   = 8;
    localparam int CAP_LSB = 8;
    localparam int PER_LSB = 16;
    localparam int WIDE_BIT = 2;
    localparam int STEP_W  = 4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REQ,
        S_BEAT,
        S_GAP,
        S_FINISH
    } seq_state_t;

    typedef struct packed {
        logic [PER_W-1:0] gap_per;
        logic [CAP_W-1:0] cap;
        logic             wide;
        logic [1:0]       sz;
    } ctrl_t;

    function automatic logic [STEP_W-1:0] beat_bytes(input logic [1:0] code);
        return STEP_W'(1) << code;
    endfunction

endpackage

// File: rtl/ilv_addr_counter.sv
module ilv_addr_counter #(
    parameter int W      = 32,
    parameter int STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [W-1:0]      load_val,
    input  logic              inc,
    input  logic [STEP_W-1:0] step,
    output logic [W-1:0]      count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (inc) begin
            count <= count + W'(step);
        end
    end

endmodule

// File: rtl/ilv_beat_join.sv
module ilv_beat_join (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic bp_ack,
    input  logic loc_ack,
    output logic bp_req,
    output logic loc_req,
    output logic complete
);

    logic bp_got;
    logic loc_got;
    logic bp_hit;
    logic loc_hit;

    always_comb begin
        bp_req   = active & ~bp_got;
        loc_req  = active & ~loc_got;
        bp_hit   = bp_got  | (bp_req  & bp_ack);
        loc_hit  = loc_got | (loc_req & loc_ack);
        complete = active & bp_hit & loc_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bp_got  <= 1'b0;
            loc_got <= 1'b0;
        end else if (!active || complete) begin
            bp_got  <= 1'b0;
            loc_got <= 1'b0;
        end else begin
            bp_got  <= bp_hit;
            loc_got <= loc_hit;
        end
    end

endmodule

// File: rtl/ilv_gap_timer.sv
module ilv_gap_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         expired
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/ilv_burst_seq.sv
module ilv_burst_seq
    import ilv_pkg::*;
#(
    parameter int BP_AW     = 32,
    parameter int LC_AW     = 32,
    parameter int LEN_W     = 16,
    parameter int CFG_DW    = 32,
    parameter int NARROW_LG = 8,
    parameter int WIDE_LG   = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic              start,
    output logic              bus_req,
    input  logic              bus_grant,
    output logic              bp_beat_req,
    input  logic              bp_beat_ack,
    output logic [BP_AW-1:0]  bp_addr,
    output logic              loc_beat_req,
    input  logic              loc_beat_ack,
    output logic [LC_AW-1:0]  loc_addr,
    output logic              gap_open,
    output logic              busy,
    output logic              done,
    output logic              irq,
    input  logic              irq_ack,
    input  logic              slv_load,
    input  logic [BP_AW-1:0]  slv_base,
    input  logic              slv_inc,
    input  logic [1:0]        slv_size,
    output logic [BP_AW-1:0]  slv_addr
);

    localparam logic [WIDE_LG-1:0] NARROW_MASK = WIDE_LG'((1 << NARROW_LG) - 1);
    localparam logic [WIDE_LG-1:0] WIDE_MASK   = '1;

    seq_state_t state, nxt;

    logic [BP_AW-1:0]  reg_bp;
    logic [LC_AW-1:0]  reg_lc;
    logic [LEN_W-1:0]  reg_len;
    ctrl_t             reg_ctrl;

    logic [LEN_W-1:0]  rem;
    logic [CAP_W-1:0]  beat_cnt;
    logic [STEP_W-1:0] step;
    logic              go;
    logic              beat_active;
    logic              beat_done;
    logic              last_beat;
    logic              boundary_hit;
    logic              cap_hit;
    logic              burst_end;
    logic              gap_load;
    logic              gap_expired;
    logic [WIDE_LG-1:0] next_lo;
    logic [WIDE_LG-1:0] line_mask;

    // configuration registers, writable only while idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_bp   <= '0;
            reg_lc   <= '0;
            reg_len  <= '0;
            reg_ctrl <= '0;
        end else if (cfg_we && state == S_IDLE) begin
            unique case (cfg_addr)
                2'd0: reg_bp  <= BP_AW'(cfg_wdata);
                2'd1: reg_lc  <= LC_AW'(cfg_wdata);
                2'd2: reg_len <= LEN_W'(cfg_wdata);
                2'd3: reg_ctrl <= '{gap_per: cfg_wdata[PER_LSB +: PER_W],
                                    cap:     cfg_wdata[CAP_LSB +: CAP_W],
                                    wide:    cfg_wdata[WIDE_BIT],
                                    sz:      cfg_wdata[1:0]};
                default: ;
            endcase
        end
    end

    assign step        = beat_bytes(reg_ctrl.sz);
    assign go          = (state == S_IDLE) && start;
    assign beat_active = (state == S_BEAT);

    ilv_beat_join u_join (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (beat_active),
        .bp_ack   (bp_beat_ack),
        .loc_ack  (loc_beat_ack),
        .bp_req   (bp_beat_req),
        .loc_req  (loc_beat_req),
        .complete (beat_done)
    );

    ilv_addr_counter #(.W(BP_AW), .STEP_W(STEP_W)) u_bp_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (go),
        .load_val (reg_bp),
        .inc      (beat_done),
        .step     (step),
        .count    (bp_addr)
    );

    ilv_addr_counter #(.W(LC_AW), .STEP_W(STEP_W)) u_lc_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (go),
        .load_val (reg_lc),
        .inc      (beat_done),
        .step     (step),
        .count    (loc_addr)
    );

    ilv_addr_counter #(.W(BP_AW), .STEP_W(STEP_W)) u_slv_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (slv_load),
        .load_val (slv_base),
        .inc      (slv_inc),
        .step     (beat_bytes(slv_size)),
        .count    (slv_addr)
    );

    ilv_gap_timer #(.W(PER_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (reg_ctrl.gap_per),
        .run      (state == S_GAP),
        .expired  (gap_expired)
    );

    // burst limit evaluation for the beat now completing
    always_comb begin
        line_mask    = reg_ctrl.wide ? WIDE_MASK : NARROW_MASK;
        next_lo      = bp_addr[WIDE_LG-1:0] + WIDE_LG'(step);
        boundary_hit = ((next_lo & line_mask) == '0);
        cap_hit      = (reg_ctrl.cap != '0) && (CAP_W'(beat_cnt + 1'b1) == reg_ctrl.cap);
        burst_end    = boundary_hit || cap_hit;
        last_beat    = (rem <= LEN_W'(step));
        gap_load     = beat_done && !last_beat && burst_end;
    end

    // remaining length and beats in the current burst
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem      <= '0;
            beat_cnt <= '0;
        end else begin
            if (go) begin
                rem <= reg_len;
            end else if (beat_done) begin
                rem <= rem - LEN_W'(step);
            end
            if (state == S_REQ) begin
                beat_cnt <= '0;
            end else if (beat_done) begin
                beat_cnt <= beat_cnt + 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (start) nxt = (reg_len == '0) ? S_FINISH : S_REQ;
            S_REQ:    if (bus_grant) nxt = S_BEAT;
            S_BEAT: begin
                if (beat_done) begin
                    if (last_beat) begin
                        nxt = S_FINISH;
                    end else if (burst_end) begin
                        nxt = S_GAP;
                    end
                end
            end
            S_GAP:    if (gap_expired) nxt = S_REQ;
            S_FINISH: nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        bus_req  = 1'b0;
        busy     = 1'b0;
        done     = 1'b0;
        gap_open = 1'b0;
        unique case (state)
            S_IDLE:   ;
            S_REQ:    begin bus_req = 1'b1; busy = 1'b1; end
            S_BEAT:   begin bus_req = 1'b1; busy = 1'b1; end
            S_GAP:    begin busy = 1'b1; gap_open = 1'b1; end
            S_FINISH: done = 1'b1;
            default:  ;
        endcase
    end

    // sticky completion interrupt
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (state == S_FINISH) begin
            irq <= 1'b1;
        end else if (irq_ack) begin
            irq <= 1'b0;
        end
    end

endmodule

// File: rtl/ilv_burst_seq_chk.sv
module ilv_burst_seq_chk #(
    parameter int BP_AW = 32,
    parameter int LC_AW = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_req,
    input logic             bp_beat_req,
    input logic             loc_beat_req,
    input logic             gap_open,
    input logic             busy,
    input logic             done,
    input logic             irq,
    input logic [BP_AW-1:0] bp_addr,
    input logic [LC_AW-1:0] loc_addr
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_req && !bp_beat_req && !loc_beat_req && !gap_open));

    assert_beat_needs_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_beat_req || loc_beat_req) |-> bus_req);

    assert_gap_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        gap_open |-> (busy && !bus_req && !bp_beat_req && !loc_beat_req));

    assert_gap_holds_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_open && $past(gap_open)) |-> ($stable(bp_addr) && $stable(loc_addr)));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_irq_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> irq);

endmodule

bind ilv_burst_seq ilv_burst_seq_chk #(.BP_AW(BP_AW), .LC_AW(LC_AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_req      (bus_req),
    .bp_beat_req  (bp_beat_req),
    .loc_beat_req (loc_beat_req),
    .gap_open     (gap_open),
    .busy         (busy),
    .done         (done),
    .irq          (irq),
    .bp_addr      (bp_addr),
    .loc_addr     (loc_addr)
);

// File: tb/ilv_burst_seq_tb.sv
`timescale 1ns/1ps
module ilv_burst_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        start = 1'b0;
    logic        bus_req;
    logic        bus_grant = 1'b0;
    logic        bp_beat_req;
    logic        bp_beat_ack = 1'b0;
    logic [31:0] bp_addr;
    logic        loc_beat_req;
    logic        loc_beat_ack = 1'b0;
    logic [31:0] loc_addr;
    logic        gap_open;
    logic        busy;
    logic        done;
    logic        irq;
    logic        irq_ack = 1'b0;
    logic        slv_load = 1'b0;
    logic [31:0] slv_base = '0;
    logic        slv_inc = 1'b0;
    logic [1:0]  slv_size = '0;
    logic [31:0] slv_addr;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    ilv_burst_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .start(start), .bus_req(bus_req),
        .bus_grant(bus_grant), .bp_beat_req(bp_beat_req),
        .bp_beat_ack(bp_beat_ack), .bp_addr(bp_addr),
        .loc_beat_req(loc_beat_req), .loc_beat_ack(loc_beat_ack),
        .loc_addr(loc_addr), .gap_open(gap_open), .busy(busy), .done(done),
        .irq(irq), .irq_ack(irq_ack), .slv_load(slv_load),
        .slv_base(slv_base), .slv_inc(slv_inc), .slv_size(slv_size),
        .slv_addr(slv_addr)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_xfer(input int sz, input int wide, input int cap, input int per,
                            input logic [31:0] bp0, input logic [31:0] loc0,
                            input int len, input bit junk, input bit prog);
        int idx = 0, inb = 0, low_run = 0, waitc = 0, cyc = 0;
        int sb = 1 << sz;
        int nbeats = len / sb;
        int bound = wide ? 2048 : 256;
        bit gap_pend = 0, open = 0, bp_ok = 0, loc_ok = 0, finished = 0;
        if (prog) begin
            cfg_write(2'd0, bp0);
            cfg_write(2'd1, loc0);
            cfg_write(2'd2, len);
            cfg_write(2'd3, {8'h00, 8'(per), 8'(cap), 5'd0, 1'(wide), 2'(sz)});
        end
        @(negedge clk);
        start = 1'b1;
        while (!finished && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            start = 1'b0; bp_beat_ack = 1'b0; loc_beat_ack = 1'b0; cfg_we = 1'b0;
            if (cyc == 1) chk(busy && bus_req, "R3 busy and request after start", {busy, bus_req}, 2'b11);
            if (junk && cyc == 3) begin
                cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 32'hDEAD_0000;
            end
            if (busy && !bus_req) begin
                low_run++;
                chk(gap_open, "R7 gap_open during release", gap_open, 1);
            end else if (bus_req && low_run > 0) begin
                chk(low_run == per + 1, "R7 release length", low_run, per + 1);
                chk(gap_pend, "R5/R6 release only at burst limit", gap_pend, 1);
                gap_pend = 0; low_run = 0;
            end
            bus_grant = bus_req;
            if (done) begin
                finished = 1;
                chk(idx == nbeats, "R8 beat count at done", idx, nbeats);
                chk(!busy && !bus_req, "R8 idle at done", {busy, bus_req}, 0);
                chk(!gap_pend, "R5/R6 no pending release at done", gap_pend, 0);
                chk(bp_addr == bp0 + len, "R8 final backplane address", bp_addr, bp0 + len);
                chk(loc_addr == loc0 + len, "R8 final local address", loc_addr, loc0 + len);
            end else if (bp_beat_req || loc_beat_req) begin
                if (!open) begin
                    open = 1; bp_ok = 0; loc_ok = 0; waitc = 0;
                    chk(!gap_pend, "R5/R6/R7 missing release before beat", gap_pend, 0);
                    chk(bp_addr == bp0 + idx * sb, "R4 backplane beat address", bp_addr, bp0 + idx * sb);
                    chk(loc_addr == loc0 + idx * sb, "R4 local beat address", loc_addr, loc0 + idx * sb);
                end else if (bp_ok) begin
                    chk(!bp_beat_req, "R4 backplane request drops after ack", bp_beat_req, 0);
                end
                if (bp_beat_req) begin bp_beat_ack = 1'b1; bp_ok = 1; end
                if (loc_beat_req && waitc >= idx % 3) begin loc_beat_ack = 1'b1; loc_ok = 1; end
                waitc++;
                if (bp_ok && loc_ok) begin
                    open = 0; idx++; inb++;
                    if (idx != nbeats && ((((bp0 + idx * sb) % bound) == 0) ||
                                          (cap != 0 && inb == cap))) begin
                        gap_pend = 1; inb = 0;
                    end
                end
            end
        end
        bus_grant = 1'b0;
        if (!finished) chk(0, "R8 transfer did not complete", 0, 1);
        @(negedge clk);
        chk(!done, "R8 done lasts one cycle", done, 0);
        chk(irq, "R9 irq after done", irq, 1);
        @(negedge clk);
        chk(irq, "R9 irq stays set", irq, 1);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk(!irq, "R9 irq cleared by ack", irq, 0);
    endtask

    initial begin
        #1_500_000;
        n_bad++;
        $display("FAIL watchdog R8 actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !bus_req && !done && !irq && !gap_open && !bp_beat_req && !loc_beat_req,
            "R1 reset state", {busy, bus_req, done, irq, gap_open, bp_beat_req, loc_beat_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R5 R6 R7 R8 R9 sweep
        for (int sz = 0; sz < 4; sz++)
            for (int wide = 0; wide < 2; wide++)
                for (int ci = 0; ci < 2; ci++)
                    for (int pi = 0; pi < 2; pi++)
                        run_xfer(sz, wide, ci * 5, pi * 3,
                                 wide ? 32'h0003_07E8 : 32'h0003_00E8,
                                 32'h0000_4008, 48, 1'b0, 1'b1);

        // R5: 64-bit mode does not split at a 256-byte line
        run_xfer(3, 1, 0, 2, 32'h0000_01E8, 32'h0000_9000, 48, 1'b0, 1'b1);

        // R2: write during busy ignored, rerun without reprogramming
        run_xfer(2, 0, 0, 1, 32'h0000_10F0, 32'h0000_2000, 32, 1'b1, 1'b1);
        run_xfer(2, 0, 0, 1, 32'h0000_10F0, 32'h0000_2000, 32, 1'b0, 1'b0);

        // R10: zero length
        cfg_write(2'd2, 32'd0);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done && !busy && !bus_req, "R10 zero length done at once", {done, busy, bus_req}, 3'b100);
        @(negedge clk);
        chk(!done && !bus_req && irq, "R10 zero length no request", {done, bus_req, irq}, 3'b001);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;

        // R11: slave counter at each size
        for (int s = 0; s < 4; s++) begin
            slv_load = 1'b1; slv_base = 32'h0000_0100 + s * 32'h40;
            @(negedge clk);
            slv_load = 1'b0;
            chk(slv_addr == slv_base, "R11 slave counter load", slv_addr, slv_base);
            slv_inc = 1'b1; slv_size = 2'(s);
            repeat (3) @(negedge clk);
            slv_inc = 1'b0;
            chk(slv_addr == slv_base + 3 * (1 << s), "R11 slave counter step", slv_addr,
                slv_base + 3 * (1 << s));
            @(negedge clk);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule